// File: doc/BRIEF.md
# Maskable Interrupt Status Unit with Vector Return

This block is a small bus-mapped register bank that gathers hardware interrupt events from several sources. Each source owns a sticky status register whose bits are set by event pulses and cleared by writing ones over the bus. Next to each status register sits a mask register. A status bit only counts as pending when its mask bit is zero. Every source folds its pending bits into a single registered flag. The flags are combined into one active-low interrupt request line.

The bus is a simple asynchronous-style strobe interface: a request strobe, read and write strobes (all active low), an address and write data. The block is selected when the upper address bits match its base address. Reads of a register drive the register value and raise the output enable. During any read that selects no register, such as an interrupt acknowledge cycle, the read data carries a fixed 8-bit vector code. That code belongs to the lowest-numbered source whose flag is set. The output enable stays low in that case, so the surrounding fabric decides whether to take the vector.

Top module: `irqv_unit`

## Requirements
- R1: After reset every status register reads 0, each mask register reads its own per-source default from `MASK_INIT`, every flag is clear and `irq_n` is 1.
- R2: Status bits are sticky: a 1 on an `evt_set` bit sets the matching status bit at the next clock edge, and it stays set until it is cleared over the bus.
- R3: A bus write to a status register clears the status bits where the write data is 1 and leaves the others alone. When a clear and a set hit the same bit in the same cycle, the clear wins and the bit ends up 0.
- R4: For source i, the status register sits at local offset 2i and the mask register at local offset 2i+1. A write to the mask register loads the write data, and a read returns the stored value.
- R5: The per-source flag is a register. It takes the OR of (status AND NOT mask) one clock edge after the status and mask values it is computed from.
- R6: `irq_n` is 0 exactly when at least one per-source flag is set.
- R7: The vector is the 8-bit constant `VEC_CODES[8i+7:8i]` of the lowest-numbered source i whose flag is set. When no flag is set, the vector is 0.
- R8: When no register read select is active, `bus_rdata` carries the current vector, zero-extended. This covers a read with the block deselected, a read of an unused offset, and no read at all.
- R9: `bus_oe` is 1 only while a register read select is active. Returning the vector never raises it.
- R10: The block is selected only when `bus_req_n` is 0 and `bus_addr[ADDR_W-1:LOC_W]` equals `BASE_ADDR >> LOC_W`. Writes made while it is deselected, or to an unused offset, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_n | input | 1 | Bus cycle request strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Register read data, or the vector when no register is read |
| bus_oe | output | 1 | High while a register read select is active |
| evt_set | input | NUM_SRC*DATA_W | Event set pulses, source i in bits [DATA_W*i +: DATA_W] |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench drives a write that clears a bit in the same cycle that an event sets it. A design with the set winning would leave the bit stuck at 1. It checks that the flag lags a status change by exactly one edge, so a combinational flag or a two-stage flag would show up as a mismatch on `irq_n`. With two sources pending, it checks that the vector belongs to the lower-numbered one, and that it falls to zero once all are cleared. Reads of unused offsets and reads with the strobe released must return the vector with `bus_oe` low. Writes outside the block must leave the mask contents unchanged when they are read back.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int VEC_W = 8;

   // number of address bits needed to reach n registers (at least 1)
   function automatic int loc_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction
endpackage

// File: rtl/irqv_decode.sv
module irqv_decode #(
   parameter int ADDR_W    = 8,
   parameter int NREG      = 6,
   parameter int LOC_W     = 3,
   parameter int BASE_ADDR = 'h40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   rd_sel,
   output logic [NREG-1:0]   wr_sel
);
   localparam int HI_W = ADDR_W - LOC_W;
   localparam logic [HI_W-1:0] BASE_HI = HI_W'(BASE_ADDR >> LOC_W);

   logic             blk_hit;
   logic [LOC_W-1:0] offs;

   assign blk_hit = !req_n && (addr[ADDR_W-1:LOC_W] == BASE_HI);
   assign offs    = addr[LOC_W-1:0];

   for (genvar r = 0; r < NREG; r++) begin : g_sel
      assign rd_sel[r] = blk_hit && !rd_n && (offs == LOC_W'(r));
      assign wr_sel[r] = blk_hit && !wr_n && (offs == LOC_W'(r));
   end

   // R10 / R9: at most one register is ever addressed
   assert_one_rdsel_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rd_sel));
   assert_no_sel_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
      req_n |-> (rd_sel == '0 && wr_sel == '0));
endmodule

// File: rtl/irqv_src.sv
module irqv_src #(
   parameter int          DATA_W   = 8,
   parameter logic [DATA_W-1:0] MASK_RST = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] evt,
   input  logic [DATA_W-1:0] wdata,
   input  logic              st_wr,
   input  logic              mk_wr,
   output logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] mask,
   output logic              flag
);
   logic [DATA_W-1:0] clr_bits;
   logic [DATA_W-1:0] st_next;

   assign clr_bits = st_wr ? wdata : '0;
   assign st_next  = (status | evt) & ~clr_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         status <= '0;
         mask   <= MASK_RST;
         flag   <= 1'b0;
      end else begin
         status <= st_next;
         if (mk_wr) mask <= wdata;
         flag <= |(status & ~mask);
      end
   end

   assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
      st_wr |=> ((status & $past(wdata)) == '0));
   assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      !st_wr |=> ((status & $past(status)) == $past(status)));
   assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
      mk_wr |=> (mask == $past(wdata)));
   assert_flag_lag_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (flag == |($past(status) & ~$past(mask))));
endmodule

// File: rtl/irqv_vecsel.sv
module irqv_vecsel #(
   parameter int DATA_W  = 8,
   parameter int NUM_SRC = 3,
   parameter int NREG    = 6,
   parameter logic [NUM_SRC*irqv_pkg::VEC_W-1:0] VEC_CODES = '0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_SRC-1:0]     flags,
   input  logic [NREG*DATA_W-1:0] reg_vals,
   input  logic [NREG-1:0]        rd_sel,
   output logic [DATA_W-1:0]      rdata,
   output logic                   oe,
   output logic                   irq_n
);
   import irqv_pkg::*;

   logic [VEC_W-1:0]  vec;
   logic [DATA_W-1:0] reg_mux;

   // lowest-numbered flagged source wins: scan from top so the last hit stays
   always_comb begin
      vec = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
         if (flags[s]) vec = VEC_CODES[s*VEC_W +: VEC_W];
      end
   end

   // AND-OR read mux; selects are one-hot or empty
   always_comb begin
      reg_mux = '0;
      for (int r = 0; r < NREG; r++) begin
         reg_mux |= reg_vals[r*DATA_W +: DATA_W] & {DATA_W{rd_sel[r]}};
      end
   end

   assign oe    = |rd_sel;
   assign rdata = oe ? reg_mux : DATA_W'(vec);
   assign irq_n = ~|flags;

   assert_vec_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (flags == '0) |-> (vec == '0));
   assert_vec_on_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_sel == '0) |-> (rdata == DATA_W'(vec)));
   assert_irq_R6: assert property (@(posedge clk) disable iff (rst)
      (flags != '0) |-> !irq_n);
endmodule

// File: rtl/irqv_unit.sv
module irqv_unit #(
   parameter int NUM_SRC   = 3,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'h40,
   parameter logic [NUM_SRC*8-1:0]      VEC_CODES = 24'h30_20_10,
   parameter logic [NUM_SRC*DATA_W-1:0] MASK_INIT = 24'hFF_00_0F
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      bus_req_n,
   input  logic                      bus_rd_n,
   input  logic                      bus_wr_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic                      bus_oe,
   input  logic [NUM_SRC*DATA_W-1:0] evt_set,
   output logic                      irq_n
);
   import irqv_pkg::*;

   localparam int NREG  = 2 * NUM_SRC;
   localparam int LOC_W = loc_bits(NREG);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("irqv_unit: NUM_SRC must be at least 1");
   end
   if (DATA_W < VEC_W) begin : g_bad_dw
      $error("irqv_unit: DATA_W must hold the 8-bit vector");
   end
   if (LOC_W >= ADDR_W) begin : g_bad_aw
      $error("irqv_unit: ADDR_W too small for the register bank");
   end
   if ((BASE_ADDR % (1 << LOC_W)) != 0) begin : g_bad_base
      $error("irqv_unit: BASE_ADDR must be aligned to the bank size");
   end

   logic [NREG-1:0]        rd_sel;
   logic [NREG-1:0]        wr_sel;
   logic [NUM_SRC-1:0]     flags;
   logic [NREG*DATA_W-1:0] reg_vals;

   irqv_decode #(
      .ADDR_W   (ADDR_W),
      .NREG     (NREG),
      .LOC_W    (LOC_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_dec (
      .clk   (clk),
      .rst   (rst),
      .req_n (bus_req_n),
      .rd_n  (bus_rd_n),
      .wr_n  (bus_wr_n),
      .addr  (bus_addr),
      .rd_sel(rd_sel),
      .wr_sel(wr_sel)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      irqv_src #(
         .DATA_W  (DATA_W),
         .MASK_RST(MASK_INIT[s*DATA_W +: DATA_W])
      ) u_src (
         .clk   (clk),
         .rst   (rst),
         .evt   (evt_set[s*DATA_W +: DATA_W]),
         .wdata (bus_wdata),
         .st_wr (wr_sel[2*s]),
         .mk_wr (wr_sel[2*s+1]),
         .status(reg_vals[(2*s)*DATA_W +: DATA_W]),
         .mask  (reg_vals[(2*s+1)*DATA_W +: DATA_W]),
         .flag  (flags[s])
      );
   end

   irqv_vecsel #(
      .DATA_W   (DATA_W),
      .NUM_SRC  (NUM_SRC),
      .NREG     (NREG),
      .VEC_CODES(VEC_CODES)
   ) u_vsel (
      .clk     (clk),
      .rst     (rst),
      .flags   (flags),
      .reg_vals(reg_vals),
      .rd_sel  (rd_sel),
      .rdata   (bus_rdata),
      .oe      (bus_oe),
      .irq_n   (irq_n)
   );

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (irq_n && flags == '0));
endmodule

// File: tb/irqv_unit_tb.sv
module irqv_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 3;
   localparam int DW = 8;
   localparam logic [23:0] VECS  = 24'h30_20_10;
   localparam logic [23:0] MINIT = 24'hFF_00_0F;

   logic clk = 0, rst = 1;
   logic req_n = 1, rd_n = 1, wr_n = 1;
   logic [7:0] addr = 0, wdata = 0;
   logic [NS*DW-1:0] evt = 0;
   logic [DW-1:0] rdata;
   logic oe, irq_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [7:0] m_st [NS];
   logic [7:0] m_mk [NS];
   logic       m_fl [NS];

   always #(CLK_PERIOD/2) clk = ~clk;

   irqv_unit u_dut (
      .clk(clk), .rst(rst), .bus_req_n(req_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_oe(oe),
      .evt_set(evt), .irq_n(irq_n)
   );

   function automatic int sel_off();
      if (!req_n && addr[7:3] == 5'd8 && addr[2:0] < 3'd6) return int'(addr[2:0]);
      return -1;
   endfunction

   function automatic logic [7:0] exp_vec();
      for (int s = 0; s < NS; s++) if (m_fl[s]) return VECS[s*8 +: 8];
      return 8'h00;
   endfunction

   function automatic logic [7:0] reg_val(int o);
      return (o % 2 == 0) ? m_st[o/2] : m_mk[o/2];
   endfunction

   function automatic logic exp_irq_n();
      logic any = 0;
      for (int s = 0; s < NS; s++) any |= m_fl[s];
      return !any;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < NS; s++) begin
         m_st[s] = 0; m_mk[s] = MINIT[s*8 +: 8]; m_fl[s] = 0;
      end
   endtask

   // compare outputs, take one edge, advance model
   task automatic cycle(string tag);
      int o;
      logic [7:0] ev;
      logic [7:0] exp_rd;
      #1;
      o = sel_off();
      if (!rd_n && o >= 0) exp_rd = reg_val(o); else exp_rd = exp_vec();
      check(rdata == exp_rd, (!rd_n && o >= 0) ? ((o % 2) ? "R4" : "R2") : {"R8 ", tag},
            rdata, exp_rd);
      check(oe == (!rd_n && o >= 0), "R9", oe, (!rd_n && o >= 0));
      check(irq_n == exp_irq_n(), "R6", irq_n, exp_irq_n());
      @(posedge clk);
      for (int s = 0; s < NS; s++) m_fl[s] = |(m_st[s] & ~m_mk[s]);
      for (int s = 0; s < NS; s++) begin
         ev = evt[s*8 +: 8];
         m_st[s] = m_st[s] | ev;
         if (!wr_n && o == 2*s) m_st[s] = m_st[s] & ~wdata;
         if (!wr_n && o == 2*s+1) m_mk[s] = wdata;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      req_n = 1; rd_n = 1; wr_n = 1; evt = 0;
   endtask

   task automatic bus_wr(logic [7:0] a, logic [7:0] d);
      req_n = 0; wr_n = 0; rd_n = 1; addr = a; wdata = d; cycle("wr"); idle();
   endtask

   task automatic bus_rd(logic [7:0] a, string tag);
      req_n = 0; rd_n = 0; wr_n = 1; addr = a; cycle(tag); idle();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      model_reset();
      repeat (3) @(negedge clk);
      rst = 0;
      // R1: reset state readback
      check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
      for (int o = 0; o < 6; o++) bus_rd(8'h40 + 8'(o), "R1");

      // R2/R5: set source1 bit, flag appears one edge later
      evt[15:8] = 8'h04; cycle("R2 set");
      evt = 0;
      check(irq_n == 1'b1, "R5 flag not yet", irq_n, 1);
      cycle("R5 lag");
      check(irq_n == 1'b0, "R5 flag up", irq_n, 0);
      check(rdata == 8'h20, "R7 vec src1", rdata, 8'h20);

      // R7: source0 also pending (unmasked bit 4) -> lower index wins
      evt[7:0] = 8'h10; cycle("R7");
      evt = 0; cycle("R7"); cycle("R7");
      check(rdata == 8'h10, "R7 priority", rdata, 8'h10);

      // R3: clear and set same bit together: clear wins
      req_n = 0; wr_n = 0; addr = 8'h42; wdata = 8'h04; evt[15:8] = 8'h04;
      cycle("R3"); idle();
      bus_rd(8'h42, "R3");
      cycle("R3");

      // R8: read of unused offset and with strobe released returns vector
      bus_rd(8'h46, "R8 unused");
      req_n = 1; rd_n = 0; addr = 8'h40; cycle("R8 deselect"); idle();

      // R10: writes outside the block are ignored
      bus_wr(8'h83, 8'hA5);
      req_n = 1; wr_n = 0; addr = 8'h43; wdata = 8'h5A; cycle("R10"); idle();
      bus_rd(8'h43, "R10");

      // R4: mask write and readback; clear everything
      bus_wr(8'h41, 8'hFF); bus_rd(8'h41, "R4");
      for (int s = 0; s < NS; s++) bus_wr(8'h40 + 8'(2*s), 8'hFF);
      cycle("R7"); cycle("R7");
      check(rdata == 8'h00, "R7 vec zero", rdata, 0);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         int k;
         k = $urandom % 8;
         req_n = ($urandom % 10) == 0;
         addr  = ($urandom % 12 == 0) ? 8'($urandom) : (8'h40 | 8'($urandom % 8));
         wdata = 8'($urandom);
         rd_n  = !(k < 3);
         wr_n  = !(k >= 3 && k < 5);
         for (int s = 0; s < NS; s++)
            evt[s*8 +: 8] = ($urandom % 4 == 0) ? (8'($urandom) & 8'($urandom)) : 8'h00;
         cycle("rand");
      end
      idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule